// File: doc/BRIEF.md
# Two-Bank Sample Swing Buffer

This block takes a stream of 16-bit samples, packs each consecutive pair into one 32-bit word and writes the words into one bank of a two-bank RAM through its write port. A host-programmed word count sets when the filling bank is full. When that count is reached, the banks trade roles. The host can then read the completed bank while new words go into the other one.

Each bank swap latches a status flag. A transfer-complete pulse from outside latches a second flag. Both flags stay set until the host clears them. A mask register decides which latched flags drive the interrupt pin. A status bit also shows the OR of both raw flags, whatever the mask holds. A write to the pointer-reset address returns the fill position to the start of bank 0.

Top module: `swing_buffer`

## Requirements
- R1: The first sample of a pair is held inside the block. On the second sample, `ram_we` is high in that same cycle and `ram_wdata` is {second sample in bits 31:16, first sample in bits 15:0}. `ram_we` stays low on the first sample.
- R2: After reset or a pointer reset, words go to bank 0 at word addresses 0, 1, 2 and so on. `ram_addr` bit 19 is the bank and bits 18:0 are the word address.
- R3: When the word at address LEN-1 is written, the next word goes to word address 0 of the other bank, so no sample is lost. `rd_bank` names the bank most recently completed, which is the one not being filled.
- R4: Writing word LEN-1 sets status bit 0 (swap) one clock later.
- R5: A one-cycle pulse on `xfer_done` sets status bit 1 (transfer complete) one clock later.
- R6: Status bit 3 reads as the OR of status bits 0 and 1. The mask has no effect on it.
- R7: Status bits stay set until a status write (address 2) has a one in their position. Writing a zero leaves a bit unchanged.
- R8: `irq` is high when status bit 0 is set with mask bit 0 set, or when status bit 1 is set with mask bit 1 set. A masked event still reads as set in status.
- R9: A write to address 3 clears the word address and the pair phase and selects bank 0. It does not change the status bits.
- R10: Register map: address 0 is LEN (19 bits), address 1 is MASK (2 bits), address 2 is STATUS, address 3 is pointer reset and reads as zero. Undefined bits read as zero.
- R11: After reset, LEN, MASK and STATUS read as zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Sample value |
| xfer_done | input | 1 | Transfer-complete event pulse |
| ram_we | output | 1 | Bank RAM write enable |
| ram_addr | output | 20 | Bank bit in the top bit, word address below it |
| ram_wdata | output | 32 | Packed sample pair |
| rd_bank | output | 1 | Bank the host may read |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Masked interrupt output |

## Verification
The RAM write port is combinational from the second sample of a pair. The bench therefore samples `ram_we`, `ram_addr` and `ram_wdata` 1 ns after driving inputs on the falling edge, which is before the edge that accepts the sample. The status flags, bank select and `rd_bank` update on the rising edge that accepts the last word or the event pulse. `irq` and the register read path follow those registers combinationally, so they are due one clock after the stimulus. The bench reads them after that edge, with `reg_addr` driven on a falling edge.

// File: rtl/swing_buffer.sv
module swing_buffer #(
  parameter int SW = 16,
  parameter int LW = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [SW-1:0]   smp_data,
  input  logic            xfer_done,
  output logic            ram_we,
  output logic [LW:0]     ram_addr,
  output logic [2*SW-1:0] ram_wdata,
  output logic            rd_bank,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq
);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [LW-1:0] len_q, wptr;
  logic [SW-1:0] lo_q;
  logic          bank, half;
  logic [1:0]    msk, sts;
  logic          ptr_rst, sts_wr, last, swap;

  assign ptr_rst   = reg_wr && reg_addr == 2'd3;
  assign sts_wr    = reg_wr && reg_addr == 2'd2;
  assign last      = wptr == len_q - ONE;
  assign ram_we    = smp_valid && half && !ptr_rst;
  assign swap      = ram_we && last;
  assign ram_addr  = {bank, wptr};
  assign ram_wdata = {smp_data, lo_q};
  assign rd_bank   = ~bank;
  assign irq       = |(sts & msk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      wptr  <= '0;
      lo_q  <= '0;
      bank  <= 1'b0;
      half  <= 1'b0;
      msk   <= '0;
      sts   <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) len_q <= reg_wdata[LW-1:0];
      if (reg_wr && reg_addr == 2'd1) msk <= reg_wdata[1:0];
      sts <= (sts & ~(sts_wr ? reg_wdata[1:0] : 2'b00)) | {xfer_done, swap};
      if (ptr_rst) begin
        wptr <= '0;
        half <= 1'b0;
        bank <= 1'b0;
      end else if (smp_valid) begin
        half <= ~half;
        if (!half) lo_q <= smp_data;
        if (half) begin
          if (last) begin
            wptr <= '0;
            bank <= ~bank;
          end else begin
            wptr <= wptr + ONE;
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[LW-1:0] = len_q;
      2'd1:    reg_rdata[1:0] = msk;
      2'd2:    reg_rdata[3:0] = {sts[0] | sts[1], 1'b0, sts};
      default: reg_rdata = '0;
    endcase
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !last) |=> (wptr == $past(wptr) + ONE && bank == $past(bank)));

  // R3
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && last) |=> (wptr == '0 && bank != $past(bank)));

  // R4
  swap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && last) |=> reg_addr != 2'd2 || reg_rdata[0]);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !(sts_wr && reg_wdata[0])) |=> sts[0]);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ram_we || xfer_done || reg_wr));

  // R9
  ptr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> (wptr == '0 && !half && !bank));
endmodule

// File: tb/test_swing_buffer.sv
module test_swing_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        xfer_done = 1'b0;
  logic        ram_we, rd_bank, irq;
  logic [19:0] ram_addr;
  logic [31:0] ram_wdata, reg_rdata;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;

  int vec = 0;
  int miss = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swing_buffer i_swing_buffer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .xfer_done(xfer_done), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .rd_bank(rd_bank), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic push_pair(input logic [15:0] a, input logic [15:0] b,
                           input logic [19:0] exp_addr, input string tag);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = a;
    #1;
    chk(ram_we == 1'b0, {tag, " R1 first half no write"}, 32'(ram_we), 32'd0);
    @(negedge clk);
    smp_data = b;
    #1;
    chk(ram_we == 1'b1, {tag, " R1 write strobe"}, 32'(ram_we), 32'd1);
    chk(ram_wdata == {b, a}, {tag, " R1 packing"}, ram_wdata, {b, a});
    chk(ram_addr == exp_addr, {tag, " R2 address"}, 32'(ram_addr), 32'(exp_addr));
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(2'd0, 32'd0, "R11 len after reset");
    rd_chk(2'd1, 32'd0, "R11 mask after reset");
    rd_chk(2'd2, 32'd0, "R11 status after reset");
    chk(irq == 1'b0, "R11 irq after reset", 32'(irq), 32'd0);
  endtask

  task automatic t_regmap;
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_chk(2'd0, 32'h0007_FFFF, "R10 len width");
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_chk(2'd1, 32'h0000_0003, "R10 mask width");
    rd_chk(2'd3, 32'd0, "R10 reset addr reads zero");
    wr_reg(2'd1, 32'd0);
  endtask

  task automatic t_fill_swap;
    wr_reg(2'd0, 32'd3);
    wr_reg(2'd3, 32'd0);
    push_pair(16'h1111, 16'h2222, 20'h00000, "fill w0");
    push_pair(16'hA5A5, 16'h5A5A, 20'h00001, "fill w1");
    rd_chk(2'd2, 32'd0, "R4 no swap before last word");
    push_pair(16'hFFFF, 16'h0001, 20'h00002, "fill w2");
    rd_chk(2'd2, 32'h9, "R4 swap flag and R6 OR bit");
    chk(rd_bank == 1'b0, "R3 rd_bank after swap", 32'(rd_bank), 32'd0);
    chk(irq == 1'b0, "R8 masked swap keeps irq low", 32'(irq), 32'd0);
    push_pair(16'h0BAD, 16'hCAFE, 20'h80000, "R3 other bank addr 0");
    push_pair(16'h0001, 16'h0002, 20'h80001, "R3 second bank w1");
    push_pair(16'h0003, 16'h0004, 20'h80002, "R3 second bank w2");
    push_pair(16'h0005, 16'h0006, 20'h00000, "R3 back to bank0");
    chk(rd_bank == 1'b1, "R3 rd_bank after second swap", 32'(rd_bank), 32'd1);
  endtask

  task automatic t_clear;
    wr_reg(2'd2, 32'd0);
    rd_chk(2'd2, 32'h9, "R7 write zero keeps flag");
    wr_reg(2'd1, 32'd1);
    #1;
    chk(irq == 1'b1, "R8 unmasked swap raises irq", 32'(irq), 32'd1);
    wr_reg(2'd2, 32'd1);
    rd_chk(2'd2, 32'd0, "R7 write one clears flag");
    chk(irq == 1'b0, "R8 irq drops after clear", 32'(irq), 32'd0);
    wr_reg(2'd1, 32'd0);
  endtask

  task automatic t_xfer;
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    rd_chk(2'd2, 32'hA, "R5 xfer flag and R6 OR bit");
    chk(irq == 1'b0, "R8 masked xfer irq low", 32'(irq), 32'd0);
    wr_reg(2'd1, 32'd1);
    chk(irq == 1'b0, "R8 wrong mask bit irq low", 32'(irq), 32'd0);
    wr_reg(2'd1, 32'd2);
    #1;
    chk(irq == 1'b1, "R8 xfer mask irq high", 32'(irq), 32'd1);
    wr_reg(2'd2, 32'd2);
    rd_chk(2'd2, 32'd0, "R7 xfer flag cleared");
    chk(irq == 1'b0, "R8 irq low after xfer clear", 32'(irq), 32'd0);
    wr_reg(2'd1, 32'd0);
  endtask

  task automatic t_ptr_reset;
    wr_reg(2'd0, 32'd2);
    push_pair(16'h1234, 16'h5678, 20'h00001, "pre reset w1");
    rd_chk(2'd2, 32'h9, "R4 swap at length two");
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 16'hDEAD;
    @(negedge clk);
    smp_valid = 1'b0;
    wr_reg(2'd3, 32'd0);
    push_pair(16'h4321, 16'h8765, 20'h00000, "R9 after pointer reset");
    rd_chk(2'd2, 32'h9, "R9 status unchanged by pointer reset");
    chk(rd_bank == 1'b1, "R9 bank 0 filling", 32'(rd_bank), 32'd1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_fill_swap();
    t_clear();
    t_xfer();
    t_ptr_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule